// File: doc/BRIEF.md
# Vector element index remapper

This block turns a linear element step count into a remapped element offset for vector operand access. A shape descriptor is loaded through a configuration port. It holds the sizes of three axes, a base offset, an output axis order code and per-axis reversal flags. The block keeps one wrap-around coordinate counter per axis, and every accepted step strobe advances them with carry. On each step it registers a remapped index, formed as a weighted sum of the current coordinates plus the base offset. It presents this index on each operand slot that the slot mask selects. Unselected slots receive the plain step count.

A start pulse rewinds a run. A run ends after the configured vector length of steps. After that, further steps are ignored until the next start. A persist flag chooses whether the slot mask survives the end of a run. When the flag is clear, the remap applies to a single run only, and later runs pass the plain step count to every slot.

Top module: `vec_idx_remap`

## Requirements
- R1: While reset is asserted, and after it is released, valid_o and done_o are 0 and every slot output is 0.
- R2: If the x size is M, the y and z sizes are 1 and the offset is K, a selected slot carries (K + (i mod M)) mod 128 for step i. For example, K=1, M=3 and length 6 give 1,2,3,1,2,3.
- R3: A y size of 0 at load is replaced by max(1, floor(cfg_maxvl_i / x size)). An x or z size of 0 counts as 1.
- R4: The x coordinate advances fastest, then y, then z, and each wraps at its size. Order code 0 gives the significance order x,y,z (least significant first), 1 gives x,z,y, 2 gives y,x,z, 3 gives y,z,x, 4 gives z,x,y and 5 gives z,y,x. Codes 6 and 7 act as 0. With sizes s, the index is c0 + c1*s0 + c2*s0*s1 + offset. For example, order 2 with sizes 3 and 2 gives 0,2,4,1,3,5.
- R5: cfg_inv_i bit 0 reverses x, bit 1 reverses y and bit 2 reverses z. A reversed axis contributes size-1-coordinate.
- R6: Slot s (bit s of cfg_mask_i, packed at slot_idx_o[7s+6:7s]) carries the remapped index when its mask bit is set. Otherwise it carries the plain step count without offset.
- R7: valid_o is high exactly in the cycle after an accepted step strobe, and low otherwise.
- R8: done_o rises with the valid of step number cfg_vl_i (1 to 127). While done_o is high, step strobes are ignored and the outputs hold.
- R9: start_i clears the step count, the coordinates and done_o. start_i takes priority over a step in the same cycle.
- R10: With persist clear, the slot mask is cleared when done_o rises. With persist set, it is kept for later runs.
- R11: A configuration load also clears the step count, the coordinates and done_o.
- R12: The remapped index is the sum taken modulo 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load descriptor and mode |
| cfg_xsz_i | input | 7 | x axis size |
| cfg_ysz_i | input | 7 | y axis size, 0 = derive |
| cfg_zsz_i | input | 7 | z axis size |
| cfg_maxvl_i | input | 7 | Maximum vector length used for derivation |
| cfg_vl_i | input | 7 | Steps per run |
| cfg_offs_i | input | 7 | Base offset |
| cfg_order_i | input | 3 | Output significance order code |
| cfg_inv_i | input | 3 | Per-axis reversal flags |
| cfg_mask_i | input | 5 | Slot remap mask |
| cfg_persist_i | input | 1 | Keep mask after run ends |
| start_i | input | 1 | Rewind run |
| step_i | input | 1 | Step strobe |
| slot_idx_o | output | 35 | Five packed 7-bit slot indices |
| valid_o | output | 1 | Slot indices updated |
| done_o | output | 1 | Run complete |

## Verification
A wrong coordinate count or a missed carry shows up in the first step past the faulty wrap as a wrong selected-slot index. A bad step count shows on the unselected slots in the same cycle. A wrong done or mask state shows as one step too many or too few, or as the following run still remapping or no longer remapping its first element. The bench compares all outputs with an integer model on every clock, so any such fault is reported in the cycle it first reaches a port.

// File: rtl/vidx_pkg.sv
package vidx_pkg;
  localparam int unsigned NAXES = 3;

  // Returns {a2,a1,a0}, least significant axis in a0 (0=x,1=y,2=z)
  function automatic logic [5:0] order_axes(input logic [2:0] code);
    case (code)
      3'd1:    return {2'd1, 2'd2, 2'd0};
      3'd2:    return {2'd2, 2'd0, 2'd1};
      3'd3:    return {2'd0, 2'd2, 2'd1};
      3'd4:    return {2'd1, 2'd0, 2'd2};
      3'd5:    return {2'd0, 2'd1, 2'd2};
      default: return {2'd2, 2'd1, 2'd0};
    endcase
  endfunction
endpackage

// File: rtl/vidx_axis_ctr.sv
module vidx_axis_ctr #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] coord_o,
  output logic         wrap_o
);
  logic [W-1:0] coord_q;

  assign wrap_o  = adv_i && (coord_q == lim_i);
  assign coord_o = coord_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     coord_q <= '0;
    else if (clr_i)  coord_q <= '0;
    else if (adv_i)  coord_q <= wrap_o ? '0 : coord_q + 1'b1;
  end

  // R4
  coord_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coord_q <= lim_i);

  // R4
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> coord_q == '0);
endmodule

// File: rtl/vidx_compose.sv
module vidx_compose
  import vidx_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic [NAXES-1:0][W-1:0] coord_i,
  input  logic [NAXES-1:0][W-1:0] size_i,
  input  logic [NAXES-1:0]        inv_i,
  input  logic [2:0]              order_i,
  input  logic [W-1:0]            offs_i,
  output logic [W-1:0]            idx_o
);
  localparam int unsigned SW = 3 * W + 2;

  logic [NAXES-1:0][W-1:0] c_eff;
  logic [5:0]              axes;
  logic [1:0]              a0, a1, a2;
  logic [SW-1:0]           t0, t1, t2, sum;

  for (genvar a = 0; a < NAXES; a++) begin : g_inv
    assign c_eff[a] = inv_i[a] ? (size_i[a] - 1'b1 - coord_i[a]) : coord_i[a];
  end

  assign axes = order_axes(order_i);
  assign a0   = axes[1:0];
  assign a1   = axes[3:2];
  assign a2   = axes[5:4];

  assign t0  = SW'(c_eff[a0]);
  assign t1  = SW'(c_eff[a1]) * SW'(size_i[a0]);
  assign t2  = SW'(c_eff[a2]) * SW'(size_i[a0]) * SW'(size_i[a1]);
  assign sum = t0 + t1 + t2 + SW'(offs_i);
  assign idx_o = sum[W-1:0];
endmodule

// File: rtl/vec_idx_remap.sv
module vec_idx_remap
  import vidx_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter int unsigned NSLOT = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [IDX_W-1:0]       cfg_xsz_i,
  input  logic [IDX_W-1:0]       cfg_ysz_i,
  input  logic [IDX_W-1:0]       cfg_zsz_i,
  input  logic [IDX_W-1:0]       cfg_maxvl_i,
  input  logic [IDX_W-1:0]       cfg_vl_i,
  input  logic [IDX_W-1:0]       cfg_offs_i,
  input  logic [2:0]             cfg_order_i,
  input  logic [2:0]             cfg_inv_i,
  input  logic [NSLOT-1:0]       cfg_mask_i,
  input  logic                   cfg_persist_i,
  input  logic                   start_i,
  input  logic                   step_i,
  output logic [NSLOT*IDX_W-1:0] slot_idx_o,
  output logic                   valid_o,
  output logic                   done_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [NAXES-1:0][IDX_W-1:0] sz_q, lim, coord;
  logic [NAXES-1:0]            adv, wrap;
  logic [IDX_W-1:0]            offs_q, vl_q, cnt_q, remap_idx;
  logic [2:0]                  ord_q, inv_q;
  logic [NSLOT-1:0]            mask_q;
  logic                        pers_q, done_q, valid_q;
  logic [NSLOT-1:0][IDX_W-1:0] slot_q, slot_d;
  logic                        clr, fire, last;
  logic [IDX_W:0]              cnt_nx;
  logic [IDX_W-1:0]            xs_new, ys_new, zs_new, ys_div;

  // descriptor normalisation at load
  assign xs_new = (cfg_xsz_i == '0) ? ONE : cfg_xsz_i;
  assign zs_new = (cfg_zsz_i == '0) ? ONE : cfg_zsz_i;
  assign ys_div = cfg_maxvl_i / xs_new;
  assign ys_new = (cfg_ysz_i != '0) ? cfg_ysz_i : ((ys_div == '0) ? ONE : ys_div);

  assign clr    = cfg_we_i | start_i;
  assign fire   = step_i & ~done_q & ~clr;
  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign last   = fire && (cnt_nx == {1'b0, vl_q});

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    assign lim[a] = sz_q[a] - 1'b1;
    if (a == 0) begin : g_first
      assign adv[a] = fire;
    end else begin : g_chain
      assign adv[a] = wrap[a-1];
    end
    vidx_axis_ctr #(.W(IDX_W)) i_ctr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .adv_i  (adv[a]),
      .lim_i  (lim[a]),
      .coord_o(coord[a]),
      .wrap_o (wrap[a])
    );
  end

  vidx_compose #(.W(IDX_W)) i_compose (
    .coord_i(coord),
    .size_i (sz_q),
    .inv_i  (inv_q),
    .order_i(ord_q),
    .offs_i (offs_q),
    .idx_o  (remap_idx)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign slot_d[s] = mask_q[s] ? remap_idx : cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sz_q    <= {NAXES{ONE}};
      offs_q  <= '0;
      vl_q    <= '0;
      ord_q   <= '0;
      inv_q   <= '0;
      mask_q  <= '0;
      pers_q  <= 1'b0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
      slot_q  <= '0;
    end else if (cfg_we_i) begin
      sz_q    <= {zs_new, ys_new, xs_new};
      offs_q  <= cfg_offs_i;
      vl_q    <= cfg_vl_i;
      ord_q   <= cfg_order_i;
      inv_q   <= cfg_inv_i;
      mask_q  <= cfg_mask_i;
      pers_q  <= cfg_persist_i;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (start_i) begin
      cnt_q   <= '0;
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        slot_q <= slot_d;
        cnt_q  <= cnt_q + 1'b1;
        if (last) begin
          done_q <= 1'b1;
          if (!pers_q) mask_q <= '0;
        end
      end
    end
  end

  assign slot_idx_o = slot_q;
  assign valid_o    = valid_q;
  assign done_o     = done_q;

  // R7
  valid_after_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !done_q && !start_i && !cfg_we_i |=> valid_o);

  // R7
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> !valid_o);

  // R8
  done_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !start_i && !cfg_we_i |=> done_q && $stable(slot_q));

  // R9
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_q && !valid_o && cnt_q == '0);

  // R10
  one_shot_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) && !pers_q |-> mask_q == '0);
endmodule

// File: tb/test_vec_idx_remap.sv
module test_vec_idx_remap;
  localparam int W  = 7;
  localparam int NS = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          cfg_we, cfg_pers, start, step;
  logic [W-1:0]  cfg_xs, cfg_ys, cfg_zs, cfg_maxvl, cfg_vl, cfg_offs;
  logic [2:0]    cfg_ord, cfg_inv;
  logic [NS-1:0] cfg_mask;
  logic [NS*W-1:0] slot_idx;
  logic          valid, done;

  vec_idx_remap i_vec_idx_remap (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we),
    .cfg_xsz_i(cfg_xs), .cfg_ysz_i(cfg_ys), .cfg_zsz_i(cfg_zs),
    .cfg_maxvl_i(cfg_maxvl), .cfg_vl_i(cfg_vl), .cfg_offs_i(cfg_offs),
    .cfg_order_i(cfg_ord), .cfg_inv_i(cfg_inv), .cfg_mask_i(cfg_mask),
    .cfg_persist_i(cfg_pers), .start_i(start), .step_i(step),
    .slot_idx_o(slot_idx), .valid_o(valid), .done_o(done)
  );

  int    n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit    finished = 0;
  int    got_q[$];

  task automatic check(string req, string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // behavioural reference model
  int m_xs, m_ys, m_zs, m_offs, m_ord, m_inv, m_mask, m_vl, m_i;
  bit m_pers, m_done, m_valid;
  int m_slot[NS];

  function automatic int ref_idx(int i);
    int c[3], s[3], ax[3];
    s[0] = m_xs; s[1] = m_ys; s[2] = m_zs;
    c[0] = i % m_xs;
    c[1] = (i / m_xs) % m_ys;
    c[2] = (i / (m_xs * m_ys)) % m_zs;
    for (int a = 0; a < 3; a++)
      if (m_inv[a]) c[a] = s[a] - 1 - c[a];
    case (m_ord)
      1: ax = '{0, 2, 1};
      2: ax = '{1, 0, 2};
      3: ax = '{1, 2, 0};
      4: ax = '{2, 0, 1};
      5: ax = '{2, 1, 0};
      default: ax = '{0, 1, 2};
    endcase
    return (m_offs + c[ax[0]] + c[ax[1]] * s[ax[0]]
            + c[ax[2]] * s[ax[0]] * s[ax[1]]) % 128;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_xs = 1; m_ys = 1; m_zs = 1; m_offs = 0; m_ord = 0; m_inv = 0;
      m_mask = 0; m_vl = 0; m_i = 0; m_pers = 0; m_done = 0; m_valid = 0;
      for (int s = 0; s < NS; s++) m_slot[s] = 0;
    end else if (cfg_we) begin
      m_xs = (cfg_xs == 0) ? 1 : int'(cfg_xs);
      m_zs = (cfg_zs == 0) ? 1 : int'(cfg_zs);
      if (cfg_ys != 0) m_ys = int'(cfg_ys);
      else begin
        m_ys = int'(cfg_maxvl) / m_xs;
        if (m_ys == 0) m_ys = 1;
      end
      m_offs = int'(cfg_offs); m_ord = int'(cfg_ord); m_inv = int'(cfg_inv);
      m_mask = int'(cfg_mask); m_pers = cfg_pers; m_vl = int'(cfg_vl);
      m_i = 0; m_done = 0; m_valid = 0;
    end else if (start) begin
      m_i = 0; m_done = 0; m_valid = 0;
    end else if (step && !m_done) begin
      for (int s = 0; s < NS; s++)
        m_slot[s] = m_mask[s] ? ref_idx(m_i) : (m_i % 128);
      m_valid = 1;
      m_i++;
      if (m_i == m_vl) begin
        m_done = 1;
        if (!m_pers) m_mask = 0;
      end
    end else begin
      m_valid = 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "valid_o", int'(valid), int'(m_valid));
      check(cur_req, "done_o", int'(done), int'(m_done));
      for (int s = 0; s < NS; s++)
        check(cur_req, $sformatf("slot%0d", s), int'(slot_idx[s*W +: W]), m_slot[s]);
      if (valid) got_q.push_back(int'(slot_idx[W-1:0]));
    end
  end

  task automatic load(int xs, int ys, int zs, int mvl, int vl, int offs,
                      int ord, int inv, int mask, bit pers);
    cfg_xs = W'(xs); cfg_ys = W'(ys); cfg_zs = W'(zs); cfg_maxvl = W'(mvl);
    cfg_vl = W'(vl); cfg_offs = W'(offs); cfg_ord = 3'(ord); cfg_inv = 3'(inv);
    cfg_mask = NS'(mask); cfg_pers = pers; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    got_q.delete();
  endtask

  task automatic steps(int n, int gap);
    for (int k = 0; k < n; k++) begin
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic restart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_q.delete();
  endtask

  task automatic expect_seq(string req, int exp[]);
    check(req, "sequence length", got_q.size(), exp.size());
    for (int k = 0; k < exp.size() && k < got_q.size(); k++)
      check(req, $sformatf("slot0 step %0d", k), got_q[k], exp[k]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_pers = 0; start = 0; step = 0;
    cfg_xs = 0; cfg_ys = 0; cfg_zs = 0; cfg_maxvl = 0; cfg_vl = 0;
    cfg_offs = 0; cfg_ord = 0; cfg_inv = 0; cfg_mask = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "valid_o in reset", int'(valid), 0);
    check("R1", "done_o in reset", int'(done), 0);
    check("R1", "slots in reset", int'(slot_idx != '0), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R6 one-dimensional modulo with offset, only slot 0 remapped
    cur_req = "R2";
    load(3, 1, 1, 6, 6, 1, 0, 0, 5'b00001, 1'b0);
    steps(6, 0);
    expect_seq("R2", '{1, 2, 3, 1, 2, 3});
    check("R6", "slot1 plain count", int'(slot_idx[2*W-1:W]), 5);
    check("R8", "done after vl", int'(done), 1);

    // R8 steps after done are ignored
    cur_req = "R8";
    steps(2, 0);
    check("R8", "valid after done", int'(valid), 0);
    check("R8", "no extra steps", got_q.size(), 6);

    // R10 one-shot mask: next run is plain
    cur_req = "R10";
    restart();
    steps(3, 0);
    expect_seq("R10", '{0, 1, 2});

    // R4 transposed order, with gaps between steps (R7)
    cur_req = "R4";
    load(3, 2, 1, 6, 6, 0, 2, 0, 5'b11111, 1'b1);
    steps(6, 2);
    expect_seq("R4", '{0, 2, 4, 1, 3, 5});
    cur_req = "R10";
    restart();
    steps(6, 0);
    expect_seq("R10", '{0, 2, 4, 1, 3, 5});

    // R3 derived y size
    cur_req = "R3";
    load(3, 0, 1, 6, 6, 0, 2, 0, 5'b00001, 1'b1);
    steps(6, 0);
    expect_seq("R3", '{0, 2, 4, 1, 3, 5});

    // R5 three axes, reversed x and z, order z,y,x, offset 5
    cur_req = "R5";
    load(2, 3, 2, 12, 12, 5, 5, 3'b101, 5'b00011, 1'b1);
    steps(12, 0);
    check("R5", "first reversed index", got_q[0], 12);
    check("R5", "run length", got_q.size(), 12);

    // R9 start mid-run
    cur_req = "R9";
    load(4, 1, 1, 8, 8, 0, 0, 0, 5'b00001, 1'b1);
    steps(3, 0);
    restart();
    check("R9", "done after start", int'(done), 0);
    steps(2, 0);
    expect_seq("R9", '{0, 1});

    // R11 configuration load rewinds
    cur_req = "R11";
    load(4, 1, 1, 8, 8, 2, 0, 0, 5'b00001, 1'b1);
    steps(2, 0);
    load(4, 1, 1, 8, 8, 2, 0, 0, 5'b00001, 1'b1);
    steps(1, 0);
    expect_seq("R11", '{2});

    // R12 index wraps at 128
    cur_req = "R12";
    load(16, 1, 1, 16, 16, 120, 0, 0, 5'b00001, 1'b1);
    steps(10, 0);
    check("R12", "wrapped index", got_q[8], 0);
    check("R12", "last index", got_q[9], 1);

    // R7 idle cycles keep valid low
    cur_req = "R7";
    repeat (3) @(negedge clk);
    check("R7", "valid idle", int'(valid), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule